// File: doc/BRIEF.md
# ALU Operand Bypass and Load-Use Interlock

This block steers the two ALU operand multiplexers of a five-stage pipeline. For each operand in the execute stage, it compares the operand's source register number with the destinations of the two younger pipeline registers. These are the execute/memory register, which holds an ALU result computed last cycle, and the memory/writeback register, which holds the value about to be written back. The block then picks the newest valid copy of the operand. When neither register matches, the operand comes from the decode/execute register as read from the register file. Bypassing never changes when the register file itself is written; that still happens only in writeback.

A loaded value exists only after the memory stage. Because of this, an instruction in decode that reads the destination of a load currently in execute cannot be served by bypassing. The block detects this case and raises a hold, which freezes the PC and the fetch/decode register, together with a bubble that zeroes the control fields entering execute. A two-state interlock machine makes sure that each load costs exactly one bubble. In state `ILK_RUN` a detected load-use pair raises the stall and takes transition `T_ARM` into `ILK_BUBBLE`. `ILK_BUBBLE` always takes transition `T_DONE` back to `ILK_RUN` after one cycle, and it never stalls. With no hazard, `ILK_RUN` stays in `ILK_RUN` (`T_IDLE`).

Top module: `fwd_unit`

## Requirements
- R1: A select value of 2'b00 picks the decode/execute register value. It is driven whenever no qualifying match exists for that operand.
- R2: When the execute/memory register has write-enable set, a nonzero destination, and a destination equal to the operand's source, the select is 2'b10.
- R3: When only the memory/writeback register qualifies (write-enable set, nonzero destination equal to the source), the select is 2'b01.
- R4: When both registers qualify for the same operand, the select is 2'b10, because the execute/memory copy is newer.
- R5: A destination of register 0, or a cleared write-enable, never produces a match.
- R6: Operand B (index 1) follows the same rules as operand A (index 0), independently of it.
- R7: When the decode/execute register holds a load (memory-read set) with a nonzero destination equal to either fetch/decode source, `hold_o` and `bubble_o` are both 1 in the same cycle.
- R8: When memory-read is clear, the load destination is 0, or neither fetch/decode source matches, `hold_o` and `bubble_o` are 0.
- R9: In the cycle after a stall, `hold_o` and `bubble_o` are 0 even if the load-use inputs are unchanged, so each load gets exactly one bubble.
- R10: While `rst_n` is low, `hold_o` and `bubble_o` are 0. The interlock leaves reset in `ILK_RUN`, so it can stall in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_src_i | input | NUM_SRC*REG_AW | Source register numbers of the operands in execute |
| exmem_dst_i | input | REG_AW | Destination in the execute/memory register |
| exmem_we_i | input | 1 | Register write-enable in the execute/memory register |
| memwb_dst_i | input | REG_AW | Destination in the memory/writeback register |
| memwb_we_i | input | 1 | Register write-enable in the memory/writeback register |
| idex_memrd_i | input | 1 | Memory-read flag of the instruction in execute |
| idex_dst_i | input | REG_AW | Destination of the instruction in execute |
| ifid_src_i | input | NUM_SRC*REG_AW | Source register numbers of the instruction in decode |
| fwd_sel_o | output | NUM_SRC*2 | Per-operand multiplexer select |
| hold_o | output | 1 | Freeze PC and fetch/decode register |
| bubble_o | output | 1 | Zero the control fields entering execute |

## Verification
The bench uses a 3-bit register space. It sweeps every combination of operand A's source, both destinations and both write-enables, and operand B's source is tied to a different register. This separates the no-match, younger-only, older-only and both-match cases, as well as the register-0 and write-disabled cases. The load-use sweep covers every load destination against every pair of decode sources, with memory-read both set and clear. It separates matches on the first source from matches on the second and from non-matches. After every stall, the same inputs are held for another cycle to show that the second bubble is suppressed. Reset is exercised with a live hazard on the inputs.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SEL_IDEX  = 2'b00,
        SEL_MEMWB = 2'b01,
        SEL_EXMEM = 2'b10
    } fwd_sel_e;

    typedef enum logic {
        ILK_RUN    = 1'b0,
        ILK_BUBBLE = 1'b1
    } ilk_state_e;

endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_i,
    input  logic [REG_AW-1:0] exmem_dst_i,
    input  logic              exmem_we_i,
    input  logic [REG_AW-1:0] memwb_dst_i,
    input  logic              memwb_we_i,
    output logic [1:0]        sel_o
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic hit_exmem;
    logic hit_memwb;

    // a producer qualifies only if it writes a real register
    assign hit_exmem = exmem_we_i && (exmem_dst_i != ZERO_REG) && (exmem_dst_i == src_i);
    assign hit_memwb = memwb_we_i && (memwb_dst_i != ZERO_REG) && (memwb_dst_i == src_i);

    // the younger result wins
    always_comb begin
        if (hit_exmem)
            sel_o = SEL_EXMEM;
        else if (hit_memwb)
            sel_o = SEL_MEMWB;
        else
            sel_o = SEL_IDEX;
    end

endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                            idex_memrd_i,
    input  logic [REG_AW-1:0]               idex_dst_i,
    input  logic [NUM_SRC-1:0][REG_AW-1:0]  ifid_src_i,
    output logic                            hazard_o
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic [NUM_SRC-1:0] src_hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
        assign src_hit[g] = (ifid_src_i[g] == idex_dst_i);
    end

    assign hazard_o = idex_memrd_i && (idex_dst_i != ZERO_REG) && (|src_hit);

endmodule

// File: rtl/ilk_fsm.sv
module ilk_fsm
    import fwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard_i,
    output logic stall_o
);

    ilk_state_e state_q;
    ilk_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ILK_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ILK_RUN:    state_d = hazard_i ? ILK_BUBBLE : ILK_RUN;
            ILK_BUBBLE: state_d = ILK_RUN;
            default:    state_d = ILK_RUN;
        endcase
    end

    always_comb begin
        stall_o = 1'b0;
        unique case (state_q)
            ILK_RUN:    stall_o = rst_n && hazard_i;
            ILK_BUBBLE: stall_o = 1'b0;
            default:    stall_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0][REG_AW-1:0] ex_src_i,
    input  logic [REG_AW-1:0]              exmem_dst_i,
    input  logic                           exmem_we_i,
    input  logic [REG_AW-1:0]              memwb_dst_i,
    input  logic                           memwb_we_i,
    input  logic                           idex_memrd_i,
    input  logic [REG_AW-1:0]              idex_dst_i,
    input  logic [NUM_SRC-1:0][REG_AW-1:0] ifid_src_i,
    output logic [NUM_SRC-1:0][1:0]        fwd_sel_o,
    output logic                           hold_o,
    output logic                           bubble_o
);

    logic hazard;
    logic stall;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
        fwd_operand_sel #(.REG_AW(REG_AW)) u_sel (
            .src_i       (ex_src_i[g]),
            .exmem_dst_i (exmem_dst_i),
            .exmem_we_i  (exmem_we_i),
            .memwb_dst_i (memwb_dst_i),
            .memwb_we_i  (memwb_we_i),
            .sel_o       (fwd_sel_o[g])
        );
    end

    load_use_detect #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_lud (
        .idex_memrd_i (idex_memrd_i),
        .idex_dst_i   (idex_dst_i),
        .ifid_src_i   (ifid_src_i),
        .hazard_o     (hazard)
    );

    ilk_fsm u_ilk (
        .clk      (clk),
        .rst_n    (rst_n),
        .hazard_i (hazard),
        .stall_o  (stall)
    );

    assign hold_o   = stall;
    assign bubble_o = stall;

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_SRC-1:0][REG_AW-1:0] ex_src_i,
    input logic [REG_AW-1:0]              exmem_dst_i,
    input logic                           exmem_we_i,
    input logic [REG_AW-1:0]              memwb_dst_i,
    input logic                           memwb_we_i,
    input logic                           idex_memrd_i,
    input logic [REG_AW-1:0]              idex_dst_i,
    input logic [NUM_SRC-1:0][REG_AW-1:0] ifid_src_i,
    input logic [NUM_SRC-1:0][1:0]        fwd_sel_o,
    input logic                           hold_o,
    input logic                           bubble_o
);

    logic any_src_eq;

    always_comb begin
        any_src_eq = 1'b0;
        for (int i = 0; i < NUM_SRC; i++)
            if (ifid_src_i[i] == idex_dst_i) any_src_eq = 1'b1;
    end

    // R9
    no_dbl_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> !hold_o);

    // R7
    bubble_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |-> (idex_memrd_i && idex_dst_i != '0 && any_src_eq && hold_o));

    // R10
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!hold_o && !bubble_o));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
        // R4
        exmem_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (exmem_we_i && exmem_dst_i != '0 && exmem_dst_i == ex_src_i[g])
            |-> fwd_sel_o[g] == 2'b10);
        // R3
        memwb_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (memwb_we_i && memwb_dst_i != '0 && memwb_dst_i == ex_src_i[g]
             && !(exmem_we_i && exmem_dst_i == ex_src_i[g]))
            |-> fwd_sel_o[g] == 2'b01);
        // R5
        zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_src_i[g] == '0) |-> fwd_sel_o[g] == 2'b00);
    end

endmodule

bind fwd_unit fwd_unit_chk #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;

    localparam int AW = 3;
    localparam int NR = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0][AW-1:0] ex_src = '0;
    logic [AW-1:0]     exmem_dst = '0;
    logic              exmem_we = 1'b0;
    logic [AW-1:0]     memwb_dst = '0;
    logic              memwb_we = 1'b0;
    logic              idex_memrd = 1'b0;
    logic [AW-1:0]     idex_dst = '0;
    logic [1:0][AW-1:0] ifid_src = '0;
    logic [1:0][1:0]   fwd_sel;
    logic              hold;
    logic              bubble;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fwd_unit #(.REG_AW(AW), .NUM_SRC(2)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ex_src_i     (ex_src),
        .exmem_dst_i  (exmem_dst),
        .exmem_we_i   (exmem_we),
        .memwb_dst_i  (memwb_dst),
        .memwb_we_i   (memwb_we),
        .idex_memrd_i (idex_memrd),
        .idex_dst_i   (idex_dst),
        .ifid_src_i   (ifid_src),
        .fwd_sel_o    (fwd_sel),
        .hold_o       (hold),
        .bubble_o     (bubble)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_sel(int s, int ed, int ew, int md, int mw);
        if (ew != 0 && ed != 0 && ed == s) return 2;
        if (mw != 0 && md != 0 && md == s) return 1;
        return 0;
    endfunction

    function automatic string sel_req(int s, int ed, int ew, int md, int mw);
        bit he = (ew != 0 && ed != 0 && ed == s);
        bit hm = (mw != 0 && md != 0 && md == s);
        if (he && hm) return "R4";
        if (he) return "R2";
        if (hm) return "R3";
        if ((ed == s && ed != 0) || (md == s && md != 0)) return "R5";
        if (ed == s || md == s) return "R5";
        return "R1";
    endfunction

    initial begin
        // R10: reset with a live load-use hazard
        idex_memrd = 1'b1; idex_dst = 3'd4; ifid_src[0] = 3'd4;
        #1;
        chk("R10 hold in reset", int'(hold), 0);
        chk("R10 bubble in reset", int'(bubble), 0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10 stall right after reset", int'(hold), 1);
        @(negedge clk); #1;
        chk("R9 second cycle after reset", int'(hold), 0);
        idex_memrd = 1'b0;
        @(negedge clk);

        // R1..R6 forwarding sweep
        for (int s = 0; s < NR; s++)
        for (int ed = 0; ed < NR; ed++)
        for (int ew = 0; ew < 2; ew++)
        for (int md = 0; md < NR; md++)
        for (int mw = 0; mw < 2; mw++) begin
            int sb = (s + 3) % NR;
            ex_src[0] = AW'(s); ex_src[1] = AW'(sb);
            exmem_dst = AW'(ed); exmem_we = ew[0];
            memwb_dst = AW'(md); memwb_we = mw[0];
            #1;
            chk(sel_req(s, ed, ew, md, mw), int'(fwd_sel[0]), exp_sel(s, ed, ew, md, mw));
            chk("R6 operand B", int'(fwd_sel[1]), exp_sel(sb, ed, ew, md, mw));
            #1;
        end

        // R7..R9 load-use sweep
        for (int d = 0; d < NR; d++)
        for (int a = 0; a < NR; a++)
        for (int b = 0; b < NR; b++)
        for (int m = 0; m < 2; m++) begin
            bit e;
            @(negedge clk);
            idex_dst = AW'(d); ifid_src[0] = AW'(a); ifid_src[1] = AW'(b);
            idex_memrd = m[0];
            #1;
            e = (m != 0) && (d != 0) && (d == a || d == b);
            chk(e ? "R7 hold" : "R8 hold", int'(hold), int'(e));
            chk(e ? "R7 bubble" : "R8 bubble", int'(bubble), int'(e));
            if (e) begin
                @(negedge clk); #1;
                chk("R9 hold next cycle", int'(hold), 0);
                chk("R9 bubble next cycle", int'(bubble), 0);
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule